// File: doc/BRIEF.md
# Dual-Clock Iterative Divider with Go/Ready Handshake

This block is an unsigned integer divider that a processor uses as a peripheral. The divider runs in its own clock domain, and that clock has no fixed relation to the processor clock. The processor side first latches a dividend and a 32-bit divisor into operand registers. On a later cycle it raises a go request. The divider domain passes go through a two-flop synchronizer and starts only on the synchronized copy. It then computes one quotient bit per divider clock using restoring shift-subtract. When it has written the result registers, it waits a programmable number of its own cycles before it raises ready.

Ready returns to the processor domain through its own two-flop synchronizer. The processor reads the quotient, remainder and the two status bits once the synchronized ready is high. It then drops go, and the divider drops ready only after it sees the synchronized go low. This closes a four-phase handshake. The wide operand and result buses cross between the domains without synchronizers. Their correctness rests on the ordering rule: data is stable before the matching control bit changes, and it stays stable until the handshake moves on.

Top module: `xdiv_xclk`

## Requirements
- R1: For a nonzero divisor, cpu_quotient is the low 32 bits of floor(dividend / divisor) and cpu_remainder is dividend mod divisor, with the dividend DVD_W bits wide (default 64).
- R2: A zero divisor sets cpu_div_zero to 1, clears cpu_overflow, and returns a quotient of all ones and a remainder equal to the low 32 bits of the dividend.
- R3: cpu_overflow is 1 exactly when the divisor is nonzero and the full quotient does not fit in 32 bits, i.e. (dividend >> 32) >= divisor; otherwise 0.
- R4: The go request reaches the divider through two divider-clock flops, and the divider leaves its idle state only when the synchronized go is high.
- R5: Ready reaches the processor through two processor-clock flops, and cpu_ready is the output of that synchronizer.
- R6: The result outputs stay unchanged from the moment ready rises, through the falling phase of the handshake, until the next computation has started.
- R7: Ready rises no earlier than SETTLE_M divider clocks after the result registers were written.
- R8: Once the divider raises ready, it holds ready until it sees the synchronized go low; after cpu_go drops, cpu_ready falls.
- R9: A rising cpu_go is not accepted while cpu_ready is still high; such a request has no effect on the divider, which is allowed to complete the return-to-zero phase.
- R10: cpu_load latches the operands only while the internal go request is low; a load during a computation does not change its result.
- R11: After either domain's synchronous active-high reset, ready is low, the divider is idle, and the result and status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Processor-domain clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| cpu_load | input | 1 | Latch cpu_dividend and cpu_divisor into the operand registers |
| cpu_dividend | input | DVD_W | Dividend value to latch |
| cpu_divisor | input | 32 | Divisor value to latch |
| cpu_go | input | 1 | Go request level (four-phase handshake) |
| cpu_ready | output | 1 | Ready flag, synchronized into the processor domain |
| cpu_quotient | output | 32 | Quotient result, valid while cpu_ready is high |
| cpu_remainder | output | 32 | Remainder result, valid while cpu_ready is high |
| cpu_div_zero | output | 1 | Divisor was zero |
| cpu_overflow | output | 1 | Quotient exceeded 32 bits |
| div_clk | input | 1 | Divider-domain clock, asynchronous to cpu_clk |
| div_rst | input | 1 | Synchronous active-high reset, divider domain |

## Verification
The embedded properties watch the handshake rules on every cycle in each domain. They check that the divider stays idle without a synchronized go, that ready is held while go is still seen high, that the result registers are frozen outside the computing state, that the settle window passes before ready, that go cannot re-arm while ready is high, and that the operands are locked while a request is active. The arithmetic (R1 to R3), the falling phase seen from the processor side, the effect of a load during a computation, and the minimum request-to-ready latency can only be shown by the bench scenarios. Those scenarios run with two unrelated clocks, a fixed-seed random operand mix, and directed zero-divisor, overflow and re-request cases.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

    localparam int DVS_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_SETTLE,
        ST_DONE
    } core_state_e;

    typedef struct packed {
        logic [DVS_W-1:0] quo;
        logic [DVS_W-1:0] rem;
        logic             dz;
        logic             ovf;
    } div_result_t;

    // One restoring step: returns {quotient bit, new partial remainder}
    function automatic logic [DVS_W:0] restore_step(
        input logic [DVS_W-1:0] part,
        input logic             next_bit,
        input logic [DVS_W-1:0] dvs
    );
        logic [DVS_W:0] trial;
        logic [DVS_W:0] diff;
        trial = {part, next_bit};
        diff  = trial - {1'b0, dvs};
        if (trial >= {1'b0, dvs})
            return {1'b1, diff[DVS_W-1:0]};
        else
            return {1'b0, trial[DVS_W-1:0]};
    endfunction

endpackage

// File: rtl/xdiv_sync.sv
module xdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/xdiv_core.sv
module xdiv_core
    import xdiv_pkg::*;
#(
    parameter int DVD_W    = 64,
    parameter int SETTLE_M = 3,
    parameter int SYNC_N   = 2
) (
    input  logic              div_clk,
    input  logic              div_rst,
    input  logic              go_async,
    input  logic [DVD_W-1:0]  dvd_in,
    input  logic [DVS_W-1:0]  dvs_in,
    output logic              ready_q,
    output div_result_t       res_q
);
    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam int SET_W = $clog2(SETTLE_M + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);
    localparam logic [SET_W-1:0] LAST_SET  = SET_W'(SETTLE_M - 1);

    logic             go_sync;
    core_state_e      state;
    logic [CNT_W-1:0] step_cnt;
    logic [SET_W-1:0] set_cnt;
    logic [DVD_W-1:0] quo_sh;
    logic [DVS_W-1:0] part_rem;
    logic [DVS_W-1:0] dvs_r;
    logic [DVS_W-1:0] dvd_low;
    logic             dz_r;
    logic             ovf_r;
    logic [DVS_W:0]   step_out;
    logic [DVD_W-1:0] quo_next;

    xdiv_sync #(.STAGES(SYNC_N)) u_go_sync (
        .clk     (div_clk),
        .rst     (div_rst),
        .d_async (go_async),
        .q_sync  (go_sync)
    );

    always_comb begin
        step_out = restore_step(part_rem, quo_sh[DVD_W-1], dvs_r);
        quo_next = {quo_sh[DVD_W-2:0], step_out[DVS_W]};
    end

    always_ff @(posedge div_clk) begin
        if (div_rst) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            set_cnt  <= '0;
            quo_sh   <= '0;
            part_rem <= '0;
            dvs_r    <= '0;
            dvd_low  <= '0;
            dz_r     <= 1'b0;
            ovf_r    <= 1'b0;
            res_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (go_sync) begin
                    dvs_r    <= dvs_in;
                    quo_sh   <= dvd_in;
                    dvd_low  <= dvd_in[DVS_W-1:0];
                    part_rem <= '0;
                    dz_r     <= (dvs_in == '0);
                    ovf_r    <= (dvs_in != '0) &&
                                ((dvd_in >> DVS_W) >= DVD_W'(dvs_in));
                    step_cnt <= (dvs_in == '0) ? LAST_STEP : '0;
                    state    <= ST_CALC;
                end
                ST_CALC: begin
                    part_rem <= step_out[DVS_W-1:0];
                    quo_sh   <= quo_next;
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) begin
                        if (dz_r)
                            res_q <= '{quo: '1, rem: dvd_low, dz: 1'b1, ovf: 1'b0};
                        else
                            res_q <= '{quo: quo_next[DVS_W-1:0],
                                       rem: step_out[DVS_W-1:0],
                                       dz: 1'b0, ovf: ovf_r};
                        set_cnt <= '0;
                        state   <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    set_cnt <= set_cnt + 1'b1;
                    if (set_cnt == LAST_SET) state <= ST_DONE;
                end
                ST_DONE: if (!go_sync) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready_q = (state == ST_DONE);

    // Checker-side age counter of the result registers
    div_result_t      res_prev;
    logic [SET_W-1:0] res_age;
    always_ff @(posedge div_clk) begin
        if (div_rst) begin
            res_prev <= '0;
            res_age  <= '0;
        end else begin
            res_prev <= res_q;
            if (res_q != res_prev)          res_age <= '0;
            else if (res_age != SET_W'(SETTLE_M)) res_age <= res_age + 1'b1;
        end
    end

    p_start_sync_r4: assert property (@(posedge div_clk) disable iff (div_rst)
        (state == ST_IDLE && !go_sync) |=> (state == ST_IDLE));

    p_hold_result_r6: assert property (@(posedge div_clk) disable iff (div_rst)
        (state != ST_CALC) |=> $stable(res_q));

    p_settle_wait_r7: assert property (@(posedge div_clk) disable iff (div_rst)
        $rose(ready_q) |-> (res_age >= SET_W'(SETTLE_M - 1)));

    p_ready_hold_r8: assert property (@(posedge div_clk) disable iff (div_rst)
        (ready_q && go_sync) |=> ready_q);

endmodule

// File: rtl/xdiv_host.sv
module xdiv_host
    import xdiv_pkg::*;
#(
    parameter int DVD_W  = 64,
    parameter int SYNC_N = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst,
    input  logic              cpu_load,
    input  logic [DVD_W-1:0]  cpu_dividend,
    input  logic [DVS_W-1:0]  cpu_divisor,
    input  logic              cpu_go,
    input  logic              ready_async,
    output logic              go_q,
    output logic [DVD_W-1:0]  dvd_q,
    output logic [DVS_W-1:0]  dvs_q,
    output logic              ready_sync
);
    xdiv_sync #(.STAGES(SYNC_N)) u_rdy_sync (
        .clk     (cpu_clk),
        .rst     (cpu_rst),
        .d_async (ready_async),
        .q_sync  (ready_sync)
    );

    always_ff @(posedge cpu_clk) begin
        if (cpu_rst) begin
            go_q  <= 1'b0;
            dvd_q <= '0;
            dvs_q <= '0;
        end else begin
            go_q <= cpu_go && (go_q || !ready_sync);
            if (cpu_load && !go_q) begin
                dvd_q <= cpu_dividend;
                dvs_q <= cpu_divisor;
            end
        end
    end

    p_go_gate_r9: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (!go_q && ready_sync) |=> !go_q);

    p_load_lock_r10: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        go_q |=> ($stable(dvd_q) && $stable(dvs_q)));

endmodule

// File: rtl/xdiv_xclk.sv
module xdiv_xclk
    import xdiv_pkg::*;
#(
    parameter int DVD_W    = 64,
    parameter int SETTLE_M = 3,
    parameter int SYNC_N   = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst,
    input  logic              cpu_load,
    input  logic [DVD_W-1:0]  cpu_dividend,
    input  logic [31:0]       cpu_divisor,
    input  logic              cpu_go,
    output logic              cpu_ready,
    output logic [31:0]       cpu_quotient,
    output logic [31:0]       cpu_remainder,
    output logic              cpu_div_zero,
    output logic              cpu_overflow,
    input  logic              div_clk,
    input  logic              div_rst
);
    logic             go_q;
    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic             ready_q;
    div_result_t      res_q;

    xdiv_host #(.DVD_W(DVD_W), .SYNC_N(SYNC_N)) u_host (
        .cpu_clk      (cpu_clk),
        .cpu_rst      (cpu_rst),
        .cpu_load     (cpu_load),
        .cpu_dividend (cpu_dividend),
        .cpu_divisor  (cpu_divisor),
        .cpu_go       (cpu_go),
        .ready_async  (ready_q),
        .go_q         (go_q),
        .dvd_q        (dvd_q),
        .dvs_q        (dvs_q),
        .ready_sync   (cpu_ready)
    );

    // Operand and result buses cross without synchronizers; ordering of go/ready covers them.
    xdiv_core #(.DVD_W(DVD_W), .SETTLE_M(SETTLE_M), .SYNC_N(SYNC_N)) u_core (
        .div_clk  (div_clk),
        .div_rst  (div_rst),
        .go_async (go_q),
        .dvd_in   (dvd_q),
        .dvs_in   (dvs_q),
        .ready_q  (ready_q),
        .res_q    (res_q)
    );

    assign cpu_quotient  = res_q.quo;
    assign cpu_remainder = res_q.rem;
    assign cpu_div_zero  = res_q.dz;
    assign cpu_overflow  = res_q.ovf;
endmodule

// File: tb/xdiv_xclk_test.sv
`timescale 1ns/1ps
module xdiv_xclk_test;
    localparam realtime CLK_PERIOD = 10.0;
    localparam realtime DIV_PERIOD = 3.7;
    localparam int      DVD_W      = 64;
    localparam int      SETTLE_M   = 3;
    localparam int      TIMEOUT    = 3000;

    logic             cpu_clk = 1'b0;
    logic             div_clk = 1'b0;
    logic             cpu_rst = 1'b1;
    logic             div_rst = 1'b1;
    logic             cpu_load = 1'b0;
    logic [DVD_W-1:0] cpu_dividend = '0;
    logic [31:0]      cpu_divisor = '0;
    logic             cpu_go = 1'b0;
    logic             cpu_ready;
    logic [31:0]      cpu_quotient;
    logic [31:0]      cpu_remainder;
    logic             cpu_div_zero;
    logic             cpu_overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) cpu_clk = ~cpu_clk;
    always #(DIV_PERIOD / 2) div_clk = ~div_clk;

    xdiv_xclk #(.DVD_W(DVD_W), .SETTLE_M(SETTLE_M)) uut (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_load(cpu_load),
        .cpu_dividend(cpu_dividend), .cpu_divisor(cpu_divisor), .cpu_go(cpu_go),
        .cpu_ready(cpu_ready), .cpu_quotient(cpu_quotient),
        .cpu_remainder(cpu_remainder), .cpu_div_zero(cpu_div_zero),
        .cpu_overflow(cpu_overflow), .div_clk(div_clk), .div_rst(div_rst)
    );

    always @(posedge cpu_clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [65:0] model(input logic [63:0] dvd, input logic [31:0] dvs);
        logic [63:0] q;
        logic [63:0] r;
        if (dvs == 0) return {1'b1, 1'b0, 32'hFFFF_FFFF, dvd[31:0]};
        q = dvd / {32'd0, dvs};
        r = dvd % {32'd0, dvs};
        return {1'b0, (q[63:32] != 0), q[31:0], r[31:0]};
    endfunction

    task automatic wait_ready(input logic lvl, output int lat);
        lat = 0;
        while (cpu_ready !== lvl && lat < TIMEOUT) begin
            @(negedge cpu_clk);
            lat++;
        end
    endtask

    task automatic load_ops(input logic [63:0] dvd, input logic [31:0] dvs);
        @(negedge cpu_clk);
        cpu_load = 1'b1; cpu_dividend = dvd; cpu_divisor = dvs;
        @(negedge cpu_clk);
        cpu_load = 1'b0;
    endtask

    task automatic check_result(input string tag, input logic [65:0] e);
        check({tag, " R1 quotient"}, 64'(cpu_quotient), 64'(e[63:32]));
        check({tag, " R1 remainder"}, 64'(cpu_remainder), 64'(e[31:0]));
        check({tag, " R2 div_zero"}, 64'(cpu_div_zero), 64'(e[65]));
        check({tag, " R3 overflow"}, 64'(cpu_overflow), 64'(e[64]));
    endtask

    task automatic run_op(input logic [63:0] dvd, input logic [31:0] dvs,
                          input bit stray_load, input bit full);
        logic [65:0] e;
        int lat;
        int min_lat;
        e = model(dvd, dvs);
        load_ops(dvd, dvs);
        cpu_go = 1'b1;
        @(negedge cpu_clk);
        if (stray_load) begin
            cpu_load = 1'b1; cpu_dividend = ~dvd; cpu_divisor = dvs ^ 32'h5A5A_0001;
            @(negedge cpu_clk);
            cpu_load = 1'b0;
        end
        wait_ready(1'b1, lat);
        check("R8 ready reached", 64'(cpu_ready), 64'd1);
        if (stray_load) check_result("R10 load during busy", e);
        else            check_result("random/directed", e);
        if (full) begin
            min_lat = int'(((dvs == 0 ? 1 : DVD_W) + SETTLE_M) * DIV_PERIOD / CLK_PERIOD) - 2;
            checks++;
            if (lat < min_lat) begin
                errors++;
                $display("FAIL R7/R4 latency: actual=%0d expected>=%0d", lat, min_lat);
            end
            repeat (3) @(negedge cpu_clk);
            check_result("R6 stable while ready", e);
        end
        cpu_go = 1'b0;
        wait_ready(1'b0, lat);
        check("R8 ready falls after go drop", 64'(cpu_ready), 64'd0);
        if (full) check_result("R6 held after handshake", e);
    endtask

    initial begin
        logic [65:0] e;
        int lat;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge cpu_clk);
        cpu_rst = 1'b0;
        div_rst = 1'b0;
        @(negedge cpu_clk);
        // R11, R5: reset state
        check("R11 ready after reset", 64'(cpu_ready), 64'd0);
        check("R11 quotient after reset", 64'(cpu_quotient), 64'd0);
        check("R11 status after reset", 64'({cpu_div_zero, cpu_overflow}), 64'd0);
        // R4: no go, nothing happens
        repeat (20) @(negedge cpu_clk);
        check("R4 idle without go", 64'(cpu_ready), 64'd0);

        // Directed corners
        run_op(64'd100, 32'd7, 1'b0, 1'b1);
        run_op(64'h0000_0001_2345_6789, 32'd0, 1'b0, 1'b1);           // R2
        run_op(64'h0000_0005_0000_0000, 32'd5, 1'b0, 1'b1);           // R3 boundary: overflow
        run_op(64'h0000_0004_FFFF_FFFF, 32'd5, 1'b0, 1'b1);           // R3 just fits
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
        run_op(64'd3, 32'd9, 1'b0, 1'b1);
        run_op(64'h0000_0000_DEAD_BEEF, 32'd1, 1'b0, 1'b1);
        run_op(64'h0000_0012_3456_789A, 32'h9876_5432, 1'b1, 1'b1);   // R10

        // R9: re-raise go while cpu_ready still high
        e = model(64'h0000_0003_0000_0010, 32'h0001_0000);
        load_ops(64'h0000_0003_0000_0010, 32'h0001_0000);
        cpu_go = 1'b1;
        wait_ready(1'b1, lat);
        check_result("R9 first pass", e);
        cpu_go = 1'b0;
        @(negedge cpu_clk);
        check("R9 ready still high at re-request", 64'(cpu_ready), 64'd1);
        cpu_go = 1'b1;
        wait_ready(1'b0, lat);
        check("R9 early request ignored, ready returns low", 64'(cpu_ready), 64'd0);
        wait_ready(1'b1, lat);
        check("R9 held request later served", 64'(cpu_ready), 64'd1);
        check_result("R9 second pass", e);
        cpu_go = 1'b0;
        wait_ready(1'b0, lat);

        // Constrained random mix
        for (int i = 0; i < 24; i++) begin
            logic [63:0] d;
            logic [31:0] s;
            d = {$urandom(), $urandom()};
            s = $urandom();
            case (i % 4)
                0: d[63:32] = s == 0 ? 32'd0 : 32'($urandom() % s);
                1: s = 32'($urandom() % 256) + 1;
                2: d = {32'd0, d[31:0]};
                default: ;
            endcase
            run_op(d, s, (i % 6) == 5, (i % 3) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule